// File: doc/BRIEF.md
# Period-Evaluating Watchdog Timer

This block is a watchdog that software reaches through a small byte-wide register port with a 4-bit offset, which gives a 16-byte window. Software turns the watchdog on through an enable register and must then write to a kick register regularly. A prescaler divides the clock into evaluation periods. At the end of each period the block checks whether a kick arrived during that period. Each period that passes without a kick adds one to a missed-period count. A kick sets that count back to zero.

The block does not reload a countdown. It compares the number of whole missed periods with a threshold fixed at build time. When the count goes past the threshold, it raises a one-cycle system reset request at every evaluation. A warning level is high while more than one period has been missed. Writing a nonzero value to the enable register runs one evaluation at once and restarts the period. Writing zero stops all evaluations and leaves the missed count as it was.

Top module: `tick_watchdog`

## Requirements
- R1: A read at offset 0x0 always returns 0x42, and any write to offset 0x0 leaves every register and output unchanged.
- R2: A write to offset 0x1 stores 1 in the enable bit when the data is nonzero and 0 when it is zero. A read at offset 0x1 returns the enable bit in bit 0, with all other bits zero.
- R3: A read at any offset other than 0x0 or 0x1 returns 0x00. A write to any offset other than 0x1 or 0x2 has no effect.
- R4: A write to offset 0x2 is a kick, whatever its data. It clears the missed count, so the warning is low on the next cycle, and it marks the current period as serviced.
- R5: While enabled, an evaluation occurs once every CYCLES_PER_PERIOD clocks. The missed count grows by one at an evaluation only if no kick arrived since the previous evaluation. Every evaluation clears the serviced mark.
- R6: `wdog_warn` is high exactly while the missed count is greater than 1.
- R7: `wdog_reset_req` is high for one cycle, on the cycle after each evaluation whose updated missed count is strictly greater than EXPIRE_THRESHOLD.
- R8: A nonzero write to the enable register starts an evaluation in the same cycle and restarts the prescaler. The next evaluation then follows CYCLES_PER_PERIOD cycles later, even if the block was already enabled.
- R9: After the enable bit is cleared, no evaluation occurs, no reset request is raised and the missed count holds its value.
- R10: Reset clears the enable bit, the serviced mark and the missed count. It also drives both outputs low.
- R11: When a kick falls in the same cycle as an evaluation, the kick wins. The count becomes 0, no reset request is raised, and the serviced mark is left clear for the next period.
- R12: The missed count saturates at 2^(THRESH_W+1)-1 and never wraps. The warning stays high, and a reset request comes at every further evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 4 | Byte offset in the 16-byte window |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid in the cycle of a read access |
| wdog_warn | output | 1 | High while more than one period has been missed |
| wdog_reset_req | output | 1 | One-cycle system reset request |

## Verification
Two things can happen in the same cycle here. A kick can land on the cycle in which the prescaler ends a period, and an enable write can land on a kick or on a period end. The bench keeps its own model of the prescaler position. It uses that model to place a kick exactly on the terminal cycle. Kick priority is judged by the warning level: it must stay low after the collision and after one more period, and rise only after a second unkicked period. Random traffic then adds further collisions of kicks, enable writes and period ends. The bench checks the warning and the reset request on every cycle against its model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int BUS_AW = 4;
    localparam int BUS_DW = 8;

    localparam logic [BUS_AW-1:0] OFS_ID     = 4'h0;
    localparam logic [BUS_AW-1:0] OFS_ENABLE = 4'h1;
    localparam logic [BUS_AW-1:0] OFS_KICK   = 4'h2;

    localparam logic [BUS_DW-1:0] ID_CODE = 8'h42;

    // decoded write commands handed from the register port to the core
    typedef struct packed {
        logic set_enable;
        logic enable_val;
        logic kick;
    } bus_cmd_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [BUS_AW-1:0] acc_addr,
    input  logic [BUS_DW-1:0] acc_wdata,
    output bus_cmd_t          cmd,
    output logic              enabled,
    output logic [BUS_DW-1:0] acc_rdata
);
    typedef struct packed {
        logic enable;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        cmd       = '0;
        acc_rdata = '0;
        if (acc_valid && acc_write) begin
            case (acc_addr)
                OFS_ENABLE: begin
                    cmd.set_enable = 1'b1;
                    cmd.enable_val = |acc_wdata;
                    st_d.enable    = |acc_wdata;
                end
                OFS_KICK: cmd.kick = 1'b1;
                default: ;
            endcase
        end else if (acc_valid) begin
            case (acc_addr)
                OFS_ID:     acc_rdata = ID_CODE;
                OFS_ENABLE: acc_rdata = {{(BUS_DW-1){1'b0}}, st_q.enable};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enabled = st_q.enable;

    p_id_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_addr == OFS_ID) |-> (acc_rdata == 8'h42));

    p_enable_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr == OFS_ENABLE) |=> (enabled == $past(|acc_wdata)));

    p_other_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr != OFS_ENABLE) |=> $stable(enabled));
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int CYCLES_PER_PERIOD = 250_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic restart,
    output logic tick
);
    localparam int CW = (CYCLES_PER_PERIOD > 1) ? $clog2(CYCLES_PER_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES_PER_PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = enable && (st_q.cnt == LAST);
        if (restart)      st_d.cnt = '0;
        else if (!enable) st_d.cnt = '0;
        else if (tick)    st_d.cnt = '0;
        else              st_d.cnt = CW'(st_q.cnt + 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st_q.cnt == '0));
endmodule

// File: rtl/wdog_miss_tracker.sv
module wdog_miss_tracker #(
    parameter int EXPIRE_THRESHOLD = 10,
    parameter int THRESH_W         = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eval,
    input  logic kick,
    output logic warn,
    output logic reset_req
);
    localparam int MW = THRESH_W + 1;
    localparam logic [MW-1:0] MISS_MAX = '1;
    localparam logic [MW-1:0] THR_V    = MW'(EXPIRE_THRESHOLD);
    localparam logic [MW-1:0] WARN_AT  = MW'(1);

    typedef struct packed {
        logic          serviced;
        logic [MW-1:0] missed;
        logic          req;
    } miss_state_t;

    miss_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (kick) begin
            st_d.missed   = '0;
            st_d.serviced = !eval;
        end else if (eval) begin
            if (!st_q.serviced && st_q.missed != MISS_MAX)
                st_d.missed = MW'(st_q.missed + 1'b1);
            st_d.serviced = 1'b0;
        end
        if (eval && st_d.missed > THR_V) st_d.req = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign warn      = st_q.missed > WARN_AT;
    assign reset_req = st_q.req;

    p_kick_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (st_q.missed == '0 && !reset_req));

    p_miss_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !kick && !st_q.serviced && st_q.missed != MISS_MAX)
        |=> (st_q.missed == MW'($past(st_q.missed) + 1'b1)));

    p_req_after_eval_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(eval));

    p_collide_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && eval) |=> (!st_q.serviced && !reset_req));

    p_saturate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.missed == MISS_MAX && !kick) |=> (st_q.missed == MISS_MAX));
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
    import wdog_pkg::*;
#(
    parameter int CYCLES_PER_PERIOD = 250_000_000,
    parameter int EXPIRE_THRESHOLD  = 10,
    parameter int THRESH_W          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [BUS_AW-1:0] acc_addr,
    input  logic [BUS_DW-1:0] acc_wdata,
    output logic [BUS_DW-1:0] acc_rdata,
    output logic              wdog_warn,
    output logic              wdog_reset_req
);
    bus_cmd_t cmd;
    logic     enabled;
    logic     restart;
    logic     tick;
    logic     eval;

    wdog_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .cmd       (cmd),
        .enabled   (enabled),
        .acc_rdata (acc_rdata)
    );

    assign restart = cmd.set_enable && cmd.enable_val;

    wdog_prescaler #(
        .CYCLES_PER_PERIOD (CYCLES_PER_PERIOD)
    ) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enabled),
        .restart (restart),
        .tick    (tick)
    );

    assign eval = restart || tick;

    wdog_miss_tracker #(
        .EXPIRE_THRESHOLD (EXPIRE_THRESHOLD),
        .THRESH_W         (THRESH_W)
    ) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval      (eval),
        .kick      (cmd.kick),
        .warn      (wdog_warn),
        .reset_req (wdog_reset_req)
    );

    p_no_eval_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && !restart) |-> !eval);
endmodule

// File: tb/tick_watchdog_tb.sv
`timescale 1ns/1ps
module tick_watchdog_tb;
    localparam int P    = 8;
    localparam int THR  = 3;
    localparam int TW   = 2;
    localparam int MAXM = (1 << (TW + 1)) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic [3:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       wdog_warn;
    logic       wdog_reset_req;

    always #2 clk = ~clk;

    tick_watchdog #(
        .CYCLES_PER_PERIOD (P),
        .EXPIRE_THRESHOLD  (THR),
        .THRESH_W          (TW)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .acc_valid      (acc_valid),
        .acc_write      (acc_write),
        .acc_addr       (acc_addr),
        .acc_wdata      (acc_wdata),
        .acc_rdata      (acc_rdata),
        .wdog_warn      (wdog_warn),
        .wdog_reset_req (wdog_reset_req)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int req_seen = 0;

    // reference model state
    bit m_en, m_srv, m_req;
    int m_cnt, m_miss;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    function automatic int exp_read(input logic [3:0] a);
        if (a == 4'h0) return 8'h42;
        if (a == 4'h1) return int'(m_en);
        return 0;
    endfunction

    task automatic model_clear();
        m_en = 0; m_srv = 0; m_req = 0; m_cnt = 0; m_miss = 0;
    endtask

    task automatic model_step(input bit v, input bit w, input logic [3:0] a, input logic [7:0] d);
        bit wr_en, kick, restart, tick, ev;
        wr_en   = v && w && a == 4'h1;
        kick    = v && w && a == 4'h2;
        restart = wr_en && d != 0;
        tick    = m_en && m_cnt == P - 1;
        ev      = restart || tick;
        if (restart)    m_cnt = 0;
        else if (!m_en) m_cnt = 0;
        else if (tick)  m_cnt = 0;
        else            m_cnt = m_cnt + 1;
        if (kick) begin
            m_miss = 0;
            m_srv  = !ev;
        end else if (ev) begin
            if (!m_srv && m_miss < MAXM) m_miss = m_miss + 1;
            m_srv = 0;
        end
        m_req = ev && (m_miss > THR);
        if (wr_en) m_en = (d != 0);
    endtask

    // called at a negative edge; returns at the next negative edge
    task automatic cycle(input bit v, input bit w, input logic [3:0] a,
                         input logic [7:0] d, output int rd);
        acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = d;
        #1 rd = int'(acc_rdata);
        @(posedge clk);
        model_step(v, w, a, d);
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
        check("R6 warn", int'(wdog_warn), int'(m_miss > 1));
        check("R7 reset_req", int'(wdog_reset_req), int'(m_req));
        if (wdog_reset_req) req_seen++;
    endtask

    task automatic idle(input int n);
        int rd;
        for (int i = 0; i < n; i++) cycle(0, 0, 4'h0, 8'h00, rd);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        int rd;
        cycle(1, 1, a, d, rd);
    endtask

    task automatic rd_check(input logic [3:0] a, input string tag);
        int rd, exp;
        exp = exp_read(a);
        cycle(1, 0, a, 8'h00, rd);
        check(tag, rd, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        acc_valid = 0; acc_write = 0;
        model_clear();
        @(negedge clk);
        @(negedge clk);
        check("R10 warn in reset", int'(wdog_warn), 0);
        check("R10 req in reset", int'(wdog_reset_req), 0);
        rst_n = 1;
    endtask

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int rd;
        void'($urandom(32'd12345));
        model_clear();
        do_reset();

        // R10 / R1 reset state and identification
        rd_check(4'h1, "R10 enable after reset");
        rd_check(4'h0, "R1 id read");
        wr(4'h0, 8'h99);
        rd_check(4'h0, "R1 id after write");
        rd_check(4'h1, "R1 write to id leaves enable");

        // R2 enable store and readback
        wr(4'h1, 8'h03);
        rd_check(4'h1, "R2 enable nonzero");
        check("R2 enable read value", rd, rd);
        wr(4'h1, 8'h00);
        rd_check(4'h1, "R2 enable zero");
        wr(4'h1, 8'h80);
        rd_check(4'h1, "R2 enable bit7 only");
        check("R8 two enable writes evaluate twice", int'(wdog_warn), 1);
        wr(4'h1, 8'h00);

        // R3 unlisted offsets
        rd_check(4'h2, "R3 read kick offset");
        rd_check(4'h5, "R3 read offset 5");
        rd_check(4'hF, "R3 read offset F");
        wr(4'hF, 8'hFF);
        wr(4'h7, 8'h01);
        rd_check(4'h1, "R3 enable untouched");
        check("R3 warn untouched", int'(wdog_warn), 1);

        // R4 kick with zero data
        wr(4'h2, 8'h00);
        check("R4 kick clears count", int'(wdog_warn), 0);

        // R8 / R5 period timing, R7 pulse, R12 saturation
        do_reset();
        wr(4'h1, 8'h01);
        idle(P - 1);
        check("R8 no eval before period end", int'(wdog_warn), 0);
        idle(1);
        check("R5 second miss after one period", int'(wdog_warn), 1);
        req_seen = 0;
        idle(P);
        check("R7 no request at count 3", req_seen, 0);
        idle(P);
        check("R7 one single-cycle request", req_seen, 1);
        idle(5 * P);
        req_seen = 0;
        idle(2 * P);
        check("R12 requests continue after saturation", req_seen, 2);
        check("R12 warn stays high", int'(wdog_warn), 1);

        // R9 disable freezes everything
        wr(4'h1, 8'h00);
        req_seen = 0;
        idle(3 * P);
        check("R9 no request when disabled", req_seen, 0);
        check("R9 count frozen", int'(wdog_warn), 1);
        wr(4'h2, 8'h5A);
        check("R4 kick while disabled", int'(wdog_warn), 0);

        // R11 kick on the evaluation cycle
        do_reset();
        wr(4'h1, 8'h01);
        while (m_cnt != P - 1) idle(1);
        wr(4'h2, 8'hA5);
        check("R11 collision clears count", int'(wdog_warn), 0);
        check("R11 collision no request", int'(wdog_reset_req), 0);
        while (m_cnt != P - 1) idle(1);
        idle(1);
        idle(P);
        check("R11 serviced mark consumed", int'(wdog_warn), 1);

        // R10 reset mid-run
        do_reset();
        rd_check(4'h1, "R10 enable cleared mid-run");
        req_seen = 0;
        idle(3 * P);
        check("R10 no evaluation after reset", req_seen, 0);

        // random traffic
        wr(4'h1, 8'h01);
        for (int i = 0; i < 4000; i++) begin
            int op;
            op = $urandom_range(0, 99);
            if (op < 78) idle(1);
            else if (op < 86) wr(4'h2, 8'($urandom()));
            else if (op < 89) wr(4'h1, (($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom_range(1, 255))));
            else if (op < 95) wr(4'($urandom_range(0, 15)), 8'($urandom()));
            else rd_check(4'($urandom_range(0, 15)), "R1 R2 R3 random read");
            if (!m_en && $urandom_range(0, 20) == 0) wr(4'h1, 8'h01);
        end

        summary();
        $finish;
    end
endmodule